// File: doc/BRIEF.md
# Inclusive First-Level Translation Buffer

This block is a small first-level address translation buffer that sits in front of a larger second-level translation buffer and holds only a subset of that buffer's entries. It has two arrays. One is a four-entry, fully associative array for pages of nine sizes, from 4 KB up to 256 MB in powers of four. The other is a 16-set, 4-way array that holds only 4 KB pages. A lookup presents a virtual page number (VPN, 4 KB granule) in one cycle. In the next cycle the block returns hit or miss, the translated physical page number and the permission bits. A new lookup can be accepted on every clock.

When a lookup misses, the block raises a miss request that carries the VPN. The second level answers with a fill, and the block installs it in the array that suits its page size. The second level also sends invalidation notices that give a VPN and a region size. The block then drops, in hardware, every entry whose page overlaps that region, so it never keeps a translation that the second level no longer holds.

Top module: `shadow_tlb`

## Requirements
- R1: After reset no entry is valid, both replacement pointers point to slot 0, and `rsp_vld` and `miss_vld` are low. Any lookup then misses.
- R2: A lookup with `lk_vld` high in cycle t gives `rsp_vld` high in cycle t+1 with `rsp_hit`, `rsp_ppn` and `rsp_perm`. `rsp_vld` is low in a cycle that follows a cycle without a lookup, and `rsp_hit` is never high without `rsp_vld`.
- R3: A fill with size code 0 (4 KB) goes to the set-associative array, in set `fill_vpn[3:0]`. That array hits when the stored VPN equals the looked-up VPN. If several ways of the set hit, the lowest-numbered way is used.
- R4: A fill with size code s from 1 to 8 (a page of 4 KB·4^s) goes to the fully associative array. That entry ignores the low 2s bits of the VPN when it matches. On a hit, `rsp_ppn` takes its low 2s bits from the looked-up VPN and its other bits from the entry.
- R5: If both arrays hit, the fully associative array wins. Among its entries that hit, the one with the lowest index wins.
- R6: Replacement is round-robin and does not look at valid bits. The fully associative array has one pointer that steps on each fill it takes. Each set of the 4-way array has its own pointer that steps on each fill into that set.
- R7: An invalidation (`inv_vld`, `inv_vpn`, size code `inv_sz`) clears every entry, in either array, whose page overlaps the aligned region of 4 KB·4^inv_sz that contains `inv_vpn`.
- R8: A lookup in the same cycle as an invalidation that overlaps the matching entry reports a miss. A lookup in the same cycle as a fill sees the contents from before the fill.
- R9: A fill whose page overlaps an invalidation in the same cycle is discarded.
- R10: `miss_vld` is high in exactly the response cycles that report a miss, and `miss_vpn` then holds the VPN that was looked up.
- R11: An accepted fill is visible to a lookup made in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vld | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| fill_vld | input | 1 | Refill from second level |
| fill_vpn | input | VPN_W | VPN of the refilled page |
| fill_ppn | input | PPN_W | Physical page number of the refilled page |
| fill_perm | input | PERM_W | Permission bits of the refilled page |
| fill_sz | input | 4 | Page size code (page = 4 KB·4^code) |
| inv_vld | input | 1 | Invalidation notice from second level |
| inv_vpn | input | VPN_W | VPN inside the invalidated region |
| inv_sz | input | 4 | Size code of the invalidated region |
| rsp_vld | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Translated page number (4 KB granule) |
| rsp_perm | output | PERM_W | Permission bits of the hit entry |
| miss_vld | output | 1 | Refill request |
| miss_vpn | output | VPN_W | VPN to refill |

## Verification
A bad valid bit or a stale tag shows up on the next lookup that touches that page. It appears one cycle later as a wrong `rsp_hit`, or as a `rsp_ppn` that comes from the wrong entry. A replacement pointer that has drifted does not show at once. It shows only when a later fill evicts a different slot, and then a lookup of the survivors hits or misses against what is expected. For this reason the stimulus refills the same sets and the same large-page slots again and again, and looks up the earlier pages after each refill. An invalidation region that is computed too small or too large shows on the first lookup after the notice.

// File: rtl/stlb_pkg.sv
package stlb_pkg;
   localparam int SZ_W    = 4;
   localparam int SZ_STEP = 2;   // each size code multiplies the page by 2**SZ_STEP

   typedef logic [SZ_W-1:0] pgsz_t;

   // bits of a 4 KB-granule page number that a page of this size ignores
   function automatic logic [31:0] span_mask(input pgsz_t sz);
      return (32'd1 << (SZ_STEP * int'(sz))) - 32'd1;
   endfunction
endpackage

// File: rtl/stlb_fa.sv
module stlb_fa
   import stlb_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int PERM_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              inv_vld,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [VPN_W-1:0]  inv_mask,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm,
   input  pgsz_t             fill_sz,
   output logic              hit,
   output logic [PPN_W-1:0]  hit_ppn,
   output logic [PERM_W-1:0] hit_perm
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [ENTRIES-1:0] vld, kill, match;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [PERM_W-1:0]  perm_q [ENTRIES];
   pgsz_t              sz_q   [ENTRIES];
   logic [PTR_W-1:0]   ptr;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic [VPN_W-1:0] em;
      assign em       = VPN_W'(span_mask(sz_q[i]));
      assign kill[i]  = inv_vld & (((inv_vpn ^ vpn_q[i]) & ~(em | inv_mask)) == '0);
      assign match[i] = vld[i] & ~kill[i] & (((lk_vpn ^ vpn_q[i]) & ~em) == '0);
   end

   always_comb begin
      logic [PPN_W-1:0] pm;
      hit      = 1'b0;
      hit_ppn  = '0;
      hit_perm = '0;
      pm       = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) begin
            pm       = PPN_W'(span_mask(sz_q[i]));
            hit      = 1'b1;
            hit_ppn  = (ppn_q[i] & ~pm) | (PPN_W'(lk_vpn) & pm);
            hit_perm = perm_q[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
         ptr <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (fill_en && ptr == PTR_W'(i)) vld[i] <= 1'b1;
            else if (kill[i])                vld[i] <= 1'b0;
         end
         if (fill_en) ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (fill_en && ptr == PTR_W'(i)) begin
            vpn_q[i]  <= fill_vpn;
            ppn_q[i]  <= fill_ppn;
            perm_q[i] <= fill_perm;
            sz_q[i]   <= fill_sz;
         end
      end
   end
endmodule

// File: rtl/stlb_sa.sv
module stlb_sa #(
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   parameter int VPN_W  = 20,
   parameter int PPN_W  = 20,
   parameter int PERM_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              inv_vld,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [VPN_W-1:0]  inv_mask,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm,
   output logic              hit,
   output logic [PPN_W-1:0]  hit_ppn,
   output logic [PERM_W-1:0] hit_perm
);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = VPN_W - IDX_W;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int NENT  = SETS * WAYS;

   logic [NENT-1:0]   vld, kill;
   logic [TAG_W-1:0]  tag_q  [NENT];
   logic [PPN_W-1:0]  ppn_q  [NENT];
   logic [PERM_W-1:0] perm_q [NENT];
   logic [IDX_W-1:0]  lk_set, fill_set;
   logic [WAY_W-1:0]  victim;

   assign lk_set   = lk_vpn[IDX_W-1:0];
   assign fill_set = fill_vpn[IDX_W-1:0];

   for (genvar e = 0; e < NENT; e++) begin : g_kill
      logic [VPN_W-1:0] ev;
      assign ev      = {tag_q[e], IDX_W'(e / WAYS)};
      assign kill[e] = inv_vld & (((inv_vpn ^ ev) & ~inv_mask) == '0);
   end

   if (WAYS > 1) begin : g_rr
      logic [WAY_W-1:0] ptr [SETS];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr[s] <= '0;
         end else if (fill_en) begin
            ptr[fill_set] <= (ptr[fill_set] == WAY_W'(WAYS - 1)) ? '0 : ptr[fill_set] + 1'b1;
         end
      end
      assign victim = ptr[fill_set];
   end else begin : g_direct
      assign victim = '0;
   end

   always_comb begin
      int e;
      hit      = 1'b0;
      hit_ppn  = '0;
      hit_perm = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         e = int'(lk_set) * WAYS + w;
         if (vld[e] && !kill[e] && tag_q[e] == lk_vpn[VPN_W-1:IDX_W]) begin
            hit      = 1'b1;
            hit_ppn  = ppn_q[e];
            hit_perm = perm_q[e];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
      end else begin
         for (int e = 0; e < NENT; e++) begin
            if (fill_en && IDX_W'(e / WAYS) == fill_set && WAY_W'(e % WAYS) == victim)
               vld[e] <= 1'b1;
            else if (kill[e])
               vld[e] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < NENT; e++) begin
         if (fill_en && IDX_W'(e / WAYS) == fill_set && WAY_W'(e % WAYS) == victim) begin
            tag_q[e]  <= fill_vpn[VPN_W-1:IDX_W];
            ppn_q[e]  <= fill_ppn;
            perm_q[e] <= fill_perm;
         end
      end
   end
endmodule

// File: rtl/shadow_tlb.sv
module shadow_tlb
   import stlb_pkg::*;
#(
   parameter int VPN_W      = 20,
   parameter int PPN_W      = 20,
   parameter int PERM_W     = 4,
   parameter int FA_ENTRIES = 4,
   parameter int SA_SETS    = 16,
   parameter int SA_WAYS    = 4,
   parameter int NUM_SIZES  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_vld,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              fill_vld,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic [3:0]        fill_sz,
   input  logic              inv_vld,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [3:0]        inv_sz,
   output logic              rsp_vld,
   output logic              rsp_hit,
   output logic [PPN_W-1:0]  rsp_ppn,
   output logic [PERM_W-1:0] rsp_perm,
   output logic              miss_vld,
   output logic [VPN_W-1:0]  miss_vpn
);
   localparam int MAX_SPAN = SZ_STEP * (NUM_SIZES - 1);

   if (MAX_SPAN >= VPN_W || VPN_W > 32) begin : g_bad_vpn
      $error("shadow_tlb: VPN_W must exceed the largest page span and be at most 32");
   end
   if (MAX_SPAN > PPN_W) begin : g_bad_ppn
      $error("shadow_tlb: PPN_W too narrow for the largest page");
   end
   if (SA_SETS < 2 || (SA_SETS & (SA_SETS - 1)) != 0) begin : g_bad_sets
      $error("shadow_tlb: SA_SETS must be a power of two, at least 2");
   end
   if (FA_ENTRIES < 1 || SA_WAYS < 1 || NUM_SIZES > (1 << SZ_W)) begin : g_bad_cfg
      $error("shadow_tlb: bad entry, way or size count");
   end

   logic [VPN_W-1:0]  inv_mask, fill_mask;
   logic              fill_ok, fa_hit, sa_hit;
   logic [PPN_W-1:0]  fa_ppn, sa_ppn;
   logic [PERM_W-1:0] fa_perm, sa_perm;

   assign inv_mask  = VPN_W'(span_mask(inv_sz));
   assign fill_mask = VPN_W'(span_mask(fill_sz));
   assign fill_ok   = fill_vld &
                      ~(inv_vld & (((fill_vpn ^ inv_vpn) & ~(fill_mask | inv_mask)) == '0));

   stlb_fa #(.ENTRIES(FA_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_fa (
      .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn),
      .inv_vld(inv_vld), .inv_vpn(inv_vpn), .inv_mask(inv_mask),
      .fill_en(fill_ok && fill_sz != '0), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_perm(fill_perm), .fill_sz(fill_sz),
      .hit(fa_hit), .hit_ppn(fa_ppn), .hit_perm(fa_perm)
   );

   stlb_sa #(.SETS(SA_SETS), .WAYS(SA_WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_sa (
      .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn),
      .inv_vld(inv_vld), .inv_vpn(inv_vpn), .inv_mask(inv_mask),
      .fill_en(fill_ok && fill_sz == '0), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_perm(fill_perm),
      .hit(sa_hit), .hit_ppn(sa_ppn), .hit_perm(sa_perm)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld  <= 1'b0;
         rsp_hit  <= 1'b0;
         rsp_ppn  <= '0;
         rsp_perm <= '0;
         miss_vpn <= '0;
      end else begin
         rsp_vld  <= lk_vld;
         rsp_hit  <= lk_vld & (fa_hit | sa_hit);
         rsp_ppn  <= fa_hit ? fa_ppn  : sa_ppn;
         rsp_perm <= fa_hit ? fa_perm : sa_perm;
         if (lk_vld) miss_vpn <= lk_vpn;
      end
   end

   assign miss_vld = rsp_vld & ~rsp_hit;
endmodule

// File: rtl/stlb_chk.sv
module stlb_chk
   import stlb_pkg::*;
#(
   parameter int VPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_vld,
   input logic [VPN_W-1:0] lk_vpn,
   input logic             fill_vld,
   input logic [VPN_W-1:0] fill_vpn,
   input logic             inv_vld,
   input logic [VPN_W-1:0] inv_vpn,
   input logic [3:0]       inv_sz,
   input logic             rsp_vld,
   input logic             rsp_hit,
   input logic [VPN_W-1:0] miss_vpn
);
   logic [VPN_W-1:0] imask;
   logic             armed;

   assign imask = VPN_W'(span_mask(inv_sz));

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R2
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_vld |=> rsp_vld);

   // R2
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_vld |=> !rsp_vld);

   // R2
   hit_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_vld);

   // R10
   miss_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_vld |=> miss_vpn == $past(lk_vpn));

   // R8
   inv_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vld && inv_vld && ((lk_vpn ^ inv_vpn) & ~imask) == '0) |=> !rsp_hit);

   // R11
   fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(fill_vld && !inv_vld) && lk_vld && !inv_vld &&
       lk_vpn == $past(fill_vpn)) |=> rsp_hit);
endmodule

bind shadow_tlb stlb_chk #(.VPN_W(VPN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_vld(lk_vld), .lk_vpn(lk_vpn),
   .fill_vld(fill_vld), .fill_vpn(fill_vpn), .inv_vld(inv_vld),
   .inv_vpn(inv_vpn), .inv_sz(inv_sz), .rsp_vld(rsp_vld),
   .rsp_hit(rsp_hit), .miss_vpn(miss_vpn)
);

// File: tb/sim_shadow_tlb.sv
module sim_shadow_tlb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_vld = 0, fill_vld = 0, inv_vld = 0;
   logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_ppn = '0, inv_vpn = '0;
   logic [3:0]  fill_perm = '0, fill_sz = '0, inv_sz = '0;
   logic        rsp_vld, rsp_hit, miss_vld;
   logic [19:0] rsp_ppn, miss_vpn;
   logic [3:0]  rsp_perm;

   int errors = 0, checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   shadow_tlb u0 (
      .clk(clk), .rst_n(rst_n), .lk_vld(lk_vld), .lk_vpn(lk_vpn),
      .fill_vld(fill_vld), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_perm(fill_perm), .fill_sz(fill_sz), .inv_vld(inv_vld),
      .inv_vpn(inv_vpn), .inv_sz(inv_sz), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
      .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm), .miss_vld(miss_vld), .miss_vpn(miss_vpn)
   );

   // reference state, built from the requirements
   logic        fa_v [4];
   logic [19:0] fa_vpn [4], fa_ppn [4];
   logic [3:0]  fa_perm [4], fa_sz [4];
   int          fa_p;
   logic        sa_v [64];
   logic [19:0] sa_vpn [64], sa_ppn [64];
   logic [3:0]  sa_perm [64];
   int          sa_p [16];

   // pending expectation for the response of the previous step
   logic        e_vld = 0, e_hit = 0;
   logic [19:0] e_ppn = '0, e_vpn = '0;
   logic [3:0]  e_perm = '0;
   string       e_tag = "R1";

   function automatic logic [19:0] smask(input logic [3:0] s);
      return 20'((32'd1 << (2 * int'(s))) - 32'd1);
   endfunction

   function automatic bit ovl(input logic [19:0] a, input logic [19:0] ma,
                              input logic [19:0] b, input logic [19:0] mb);
      return ((a ^ b) & ~(ma | mb)) == 20'd0;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) fa_v[i] = 0;
      for (int i = 0; i < 64; i++) sa_v[i] = 0;
      for (int i = 0; i < 16; i++) sa_p[i] = 0;
      fa_p = 0;
   endtask

   task automatic step(input bit lv, input logic [19:0] lvpn,
                       input bit fv, input logic [19:0] fvpn, input logic [19:0] fppn,
                       input logic [3:0] fperm, input logic [3:0] fsz,
                       input bit iv, input logic [19:0] ivpn, input logic [3:0] isz,
                       input string tag);
      logic [19:0] im, fm;
      bit h, fok;
      bit kfa [4];
      bit ksa [64];
      logic [19:0] p;
      logic [3:0]  pr;
      string       t;
      // compare response from the previous step
      check(rsp_vld == e_vld, "R2", "rsp_vld", 32'(rsp_vld), 32'(e_vld));
      if (e_vld) begin
         check(rsp_hit == e_hit, e_tag, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
         check(miss_vld == !e_hit, "R10", "miss_vld", 32'(miss_vld), 32'(!e_hit));
         if (e_hit && rsp_hit) begin
            check(rsp_ppn == e_ppn, e_tag, "rsp_ppn", 32'(rsp_ppn), 32'(e_ppn));
            check(rsp_perm == e_perm, e_tag, "rsp_perm", 32'(rsp_perm), 32'(e_perm));
         end
         if (!e_hit)
            check(miss_vpn == e_vpn, "R10", "miss_vpn", 32'(miss_vpn), 32'(e_vpn));
      end else begin
         check(miss_vld == 1'b0, "R10", "miss_vld idle", 32'(miss_vld), 32'd0);
      end
      // kills from this cycle's invalidation (R7)
      im = smask(isz);
      for (int i = 0; i < 4; i++)  kfa[i] = iv && ovl(ivpn, im, fa_vpn[i], smask(fa_sz[i]));
      for (int i = 0; i < 64; i++) ksa[i] = iv && ovl(ivpn, im, sa_vpn[i], 20'd0);
      // lookup against pre-update contents (R5, R8)
      h = 0; p = '0; pr = '0; t = tag;
      if (lv) begin
         for (int w = 3; w >= 0; w--) begin
            int e = int'(lvpn[3:0]) * 4 + w;
            if (sa_v[e] && !ksa[e] && sa_vpn[e] == lvpn) begin
               h = 1; p = sa_ppn[e]; pr = sa_perm[e];
               if (tag == "") t = "R3";
            end
         end
         for (int i = 3; i >= 0; i--) begin
            if (fa_v[i] && !kfa[i] && ovl(lvpn, smask(fa_sz[i]), fa_vpn[i], 20'd0)) begin
               h = 1; p = (fa_ppn[i] & ~smask(fa_sz[i])) | (lvpn & smask(fa_sz[i]));
               pr = fa_perm[i];
               if (tag == "") t = "R4";
            end
         end
         if (tag == "" && !h) t = "R10";
      end
      e_vld = lv; e_hit = h; e_ppn = p; e_perm = pr; e_vpn = lvpn; e_tag = t;
      // state update (R6, R7, R9)
      fm  = smask(fsz);
      fok = fv && !(iv && ovl(fvpn, fm, ivpn, im));
      for (int i = 0; i < 4; i++)  if (kfa[i]) fa_v[i] = 0;
      for (int i = 0; i < 64; i++) if (ksa[i]) sa_v[i] = 0;
      if (fok && fsz != 0) begin
         fa_v[fa_p] = 1; fa_vpn[fa_p] = fvpn; fa_ppn[fa_p] = fppn;
         fa_perm[fa_p] = fperm; fa_sz[fa_p] = fsz;
         fa_p = (fa_p + 1) % 4;
      end else if (fok) begin
         int s = int'(fvpn[3:0]);
         int e = s * 4 + sa_p[s];
         sa_v[e] = 1; sa_vpn[e] = fvpn; sa_ppn[e] = fppn; sa_perm[e] = fperm;
         sa_p[s] = (sa_p[s] + 1) % 4;
      end
      lk_vld = lv; lk_vpn = lvpn;
      fill_vld = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm; fill_sz = fsz;
      inv_vld = iv; inv_vpn = ivpn; inv_sz = isz;
      @(negedge clk);
   endtask

   task automatic look(input logic [19:0] v, input string tag);
      step(1, v, 0, '0, '0, '0, '0, 0, '0, '0, tag);
   endtask

   task automatic fill(input logic [19:0] v, input logic [19:0] p,
                       input logic [3:0] pr, input logic [3:0] sz);
      step(0, '0, 1, v, p, pr, sz, 0, '0, '0, "");
   endtask

   function automatic logic [19:0] rvpn();
      return 20'(($urandom % 4) << 16) | 20'($urandom % 128);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset, first lookup misses
      check(rsp_vld == 0 && miss_vld == 0, "R1", "outputs after reset",
            32'({rsp_vld, miss_vld}), 32'd0);
      look(20'h00012, "R1");
      // R3 / R11: 4 KB fill then hit
      fill(20'h00012, 20'hABCDE, 4'h5, 4'd0);
      look(20'h00012, "R11");
      // R8: lookup with fill in same cycle sees old contents
      step(1, 20'h00034, 1, 20'h00034, 20'h34343, 4'h3, 4'd0, 0, '0, '0, "R8");
      look(20'h00034, "R11");
      // R4: 64 KB page, low VPN bits pass through
      fill(20'h10000, 20'h55550, 4'h7, 4'd2);
      look(20'h1000B, "R4");
      // R5: both arrays hit, large-page array wins
      fill(20'h1000B, 20'h11111, 4'h1, 4'd0);
      look(20'h1000B, "R5");
      // R8: invalidation in the lookup cycle forces miss, R7 stays dropped
      step(1, 20'h00012, 0, '0, '0, '0, '0, 1, 20'h00012, 4'd0, "R8");
      look(20'h00012, "R7");
      // R9: fill overlapping same-cycle invalidation is discarded
      step(0, '0, 1, 20'h00077, 20'h77777, 4'h2, 4'd0, 1, 20'h00070, 4'd2, "");
      look(20'h00077, "R9");
      // R7: wide invalidation removes both large page and 4 KB entry
      step(0, '0, 0, '0, '0, '0, '0, 1, 20'h10000, 4'd4, "");
      look(20'h1000B, "R7");
      look(20'h10003, "R7");
      // R6: round robin in the large-page array
      for (int k = 0; k < 5; k++) fill(20'h20000 + 20'(k * 16), 20'h30000 + 20'(k * 16), 4'h4, 4'd1);
      for (int k = 0; k < 5; k++) look(20'h20001 + 20'(k * 16), "R6");
      // R6: round robin within one 4 KB set
      for (int k = 1; k <= 5; k++) fill(20'h00005 + 20'(k * 256), 20'h40000 + 20'(k), 4'h6, 4'd0);
      for (int k = 1; k <= 5; k++) look(20'h00005 + 20'(k * 256), "R6");
      // random mix
      for (int n = 0; n < 4000; n++) begin
         bit lv, fv, iv;
         logic [3:0] fsz, isz;
         lv  = ($urandom % 4) != 0;
         fv  = ($urandom % 3) == 0;
         iv  = ($urandom % 10) == 0;
         fsz = (($urandom % 10) < 7) ? 4'd0 : 4'(1 + $urandom % 4);
         isz = 4'($urandom % 4);
         step(lv, rvpn(), fv, rvpn(), 20'($urandom), 4'($urandom), fsz, iv, rvpn(), isz, "");
      end
      step(0, '0, 0, '0, '0, '0, '0, 0, '0, '0, "");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule